// File: doc/BRIEF.md
# DRAM Refresh Interval Timer with CAS-before-RAS Sequencer

The block paces DRAM refresh. A free-running prescaler divides the system clock by one of seven ratios chosen by a 3-bit select code. An 8-bit interval counter advances by one on each divided tick. When a tick finds the counter equal to the compare value, the counter returns to zero and, if refresh is enabled, the block raises a bus request.

Once the bus is granted, the block drives a fixed CAS-before-RAS cycle on its active-low strobes and then releases the request. A compare match that arrives while a request is still waiting for the bus is lost. So is a match that arrives while a refresh cycle is running. Matches are never counted up for later service.

Software loads the counter and the compare value through dedicated write strobes before it writes a nonzero select code. The counter stays frozen while the select code is zero.

Top module: `refr_timer_top`

## Requirements
- R1: No bus request is ever raised while the refresh enable flag is 0, even though the counter still counts and wraps.
- R2: While the select code is 000 the counter holds its value.
- R3: Select codes 1, 2, 3, 4, 5, 6 and 7 make the counter advance exactly once every 2, 8, 32, 128, 512, 2048 and 4096 clocks respectively.
- R4: On a tick that finds the counter equal to the compare value, the counter becomes 0x00 in the next cycle instead of incrementing. The counter therefore cycles through 0 up to the compare value and back to 0.
- R5: The bus request goes high in the cycle after an enabled match. It stays high until the refresh cycle has completed. The strobes stay high until the grant input is sampled high while the request is pending.
- R6: In the clock after the grant is sampled, casN is low and rasN is high for one clock. Then both strobes are low for two clocks. Then both are high for one precharge clock with the request still high. The request drops in the clock after that.
- R7: Matches that occur while a request is waiting for the grant are discarded. Granting the bus produces exactly one refresh cycle, after which the request stays low.
- R8: A match that occurs during a refresh cycle is discarded, and no request follows the cycle. The counter still returns to 0.
- R9: A counter write in a given clock loads the written value. It overrides both the increment and the compare reset, and it produces no match in that clock.
- R10: After reset the counter reads 0, the bus request is low, and both strobes are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cntWrEn | input | 1 | Counter write strobe |
| cntWrData | input | 8 | Value loaded into the counter |
| cmpWrEn | input | 1 | Compare register write strobe |
| cmpWrData | input | 8 | Compare value |
| selWrEn | input | 1 | Select-code write strobe |
| selWrData | input | 3 | Prescaler select code (000 stops counting) |
| enWrEn | input | 1 | Refresh-enable write strobe |
| enWrData | input | 1 | Refresh enable value |
| busGrant | input | 1 | Bus grant to the refresh sequencer |
| busReq | output | 1 | Bus request from the refresh sequencer |
| rasN | output | 1 | Row strobe, active low |
| casN | output | 1 | Column strobe, active low |
| cntValue | output | 8 | Current counter value |

## Verification
Two pairs of events can land in the same clock. The first pair is a counter write and a compare-match tick. The bench provokes this by holding a write of the compare value across many prescaler ticks, then checks that the counter keeps the written value and that no request appears. The second pair is a compare match and a refresh cycle that is already running. The bench provokes this by reloading the counter with the compare value just as the grant starts the cycle. It judges the result from the full strobe sequence, a counter that has returned near zero, and a request that stays low afterwards.

// File: rtl/refr_pkg.sv
package refr_pkg;

  localparam int CNT_BITS = 8;
  localparam int SEL_BITS = 3;
  localparam int PRE_BITS = 12;

  // log2 of the division ratio for a nonzero select code
  function automatic int divExp(input int code);
    if (code >= 7) return 12;
    return 2 * code - 1;
  endfunction

  typedef struct packed {
    logic tick;
    logic match;
  } refr_evt_t;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_WAIT = 3'd1,
    ST_CAS  = 3'd2,
    ST_RAS1 = 3'd3,
    ST_RAS2 = 3'd4,
    ST_PRE  = 3'd5
  } refr_state_t;

endpackage

// File: rtl/refr_datapath.sv
module refr_datapath
  import refr_pkg::*;
#(
  parameter int CNT_W = CNT_BITS,
  parameter int SEL_W = SEL_BITS,
  parameter int PRE_W = PRE_BITS
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cntWrEn,
  input  logic [CNT_W-1:0] cntWrData,
  input  logic             cmpWrEn,
  input  logic [CNT_W-1:0] cmpWrData,
  input  logic             selWrEn,
  input  logic [SEL_W-1:0] selWrData,
  input  logic             enWrEn,
  input  logic             enWrData,
  output logic [CNT_W-1:0] cntValue,
  output logic [SEL_W-1:0] selCode,
  output logic             enFlag,
  output refr_evt_t        evt
);

  localparam int NUM_CODES = 1 << SEL_W;

  logic [PRE_W-1:0]     preCnt;
  logic [CNT_W-1:0]     cmpReg;
  logic [NUM_CODES-1:0] tickVec;
  logic                 tick;
  logic                 hit;

  // free-running prescaler
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) preCnt <= '0;
    else       preCnt <= preCnt + PRE_W'(1);
  end

  assign tickVec[0] = 1'b0;
  generate
    for (genvar c = 1; c < NUM_CODES; c++) begin : g_tap
      localparam int E = divExp(c);
      localparam logic [PRE_W-1:0] MASK = PRE_W'((64'd1 << E) - 64'd1);
      assign tickVec[c] = ((preCnt & MASK) == MASK);
    end
  endgenerate

  assign tick = tickVec[selCode];
  assign hit  = tick && !cntWrEn && (cntValue == cmpReg);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmpReg  <= '1;
      selCode <= '0;
      enFlag  <= 1'b0;
    end else begin
      if (cmpWrEn) cmpReg  <= cmpWrData;
      if (selWrEn) selCode <= selWrData;
      if (enWrEn)  enFlag  <= enWrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        cntValue <= '0;
    else if (cntWrEn) cntValue <= cntWrData;
    else if (tick) begin
      if (cntValue == cmpReg) cntValue <= '0;
      else                    cntValue <= cntValue + CNT_W'(1);
    end
  end

  assign evt.tick  = tick;
  assign evt.match = hit;

endmodule

// File: rtl/refr_control.sv
module refr_control
  import refr_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  refr_evt_t evt,
  input  logic      enFlag,
  input  logic      busGrant,
  output logic      busReq,
  output logic      rasN,
  output logic      casN
);

  refr_state_t state, nextState;

  always_comb begin
    nextState = state;
    unique case (state)
      ST_IDLE: if (evt.match && enFlag) nextState = ST_WAIT;
      ST_WAIT: if (busGrant)            nextState = ST_CAS;
      ST_CAS:                           nextState = ST_RAS1;
      ST_RAS1:                          nextState = ST_RAS2;
      ST_RAS2:                          nextState = ST_PRE;
      ST_PRE:                           nextState = ST_IDLE;
      default:                          nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  assign busReq = (state != ST_IDLE);
  assign casN   = !(state inside {ST_CAS, ST_RAS1, ST_RAS2});
  assign rasN   = !(state inside {ST_RAS1, ST_RAS2});

endmodule

// File: rtl/refr_timer_top.sv
module refr_timer_top
  import refr_pkg::*;
#(
  parameter int CNT_W = CNT_BITS,
  parameter int SEL_W = SEL_BITS,
  parameter int PRE_W = PRE_BITS
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cntWrEn,
  input  logic [CNT_W-1:0] cntWrData,
  input  logic             cmpWrEn,
  input  logic [CNT_W-1:0] cmpWrData,
  input  logic             selWrEn,
  input  logic [SEL_W-1:0] selWrData,
  input  logic             enWrEn,
  input  logic             enWrData,
  input  logic             busGrant,
  output logic             busReq,
  output logic             rasN,
  output logic             casN,
  output logic [CNT_W-1:0] cntValue
);

  refr_evt_t        evt;
  logic             enFlag;
  logic [SEL_W-1:0] selCode;

  refr_datapath #(.CNT_W(CNT_W), .SEL_W(SEL_W), .PRE_W(PRE_W)) u_dp (
    .clk(clk), .rstN(rstN),
    .cntWrEn(cntWrEn), .cntWrData(cntWrData),
    .cmpWrEn(cmpWrEn), .cmpWrData(cmpWrData),
    .selWrEn(selWrEn), .selWrData(selWrData),
    .enWrEn(enWrEn), .enWrData(enWrData),
    .cntValue(cntValue), .selCode(selCode), .enFlag(enFlag), .evt(evt)
  );

  refr_control u_ctl (
    .clk(clk), .rstN(rstN), .evt(evt), .enFlag(enFlag),
    .busGrant(busGrant), .busReq(busReq), .rasN(rasN), .casN(casN)
  );

endmodule

// File: rtl/refr_checker.sv
module refr_checker #(
  parameter int CNT_W = 8,
  parameter int SEL_W = 3
) (
  input logic             clk,
  input logic             rstN,
  input logic             cntWrEn,
  input logic [CNT_W-1:0] cntWrData,
  input logic [CNT_W-1:0] cntValue,
  input logic [SEL_W-1:0] selCode,
  input logic             enFlag,
  input logic             busGrant,
  input logic             busReq,
  input logic             rasN,
  input logic             casN
);

  AST_REQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busReq) |-> $past(enFlag)); // R1

  AST_HOLD_WHEN_STOPPED: assert property (@(posedge clk) disable iff (!rstN)
    (selCode == '0 && !cntWrEn) |=> $stable(cntValue)); // R2

  AST_STROBE_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rstN)
    !casN |-> busReq); // R5

  AST_CYCLE_AFTER_GRANT: assert property (@(posedge clk) disable iff (!rstN)
    $fell(casN) |-> $past(busGrant)); // R5

  AST_RAS_UNDER_CAS: assert property (@(posedge clk) disable iff (!rstN)
    !rasN |-> !casN); // R6

  AST_CAS_LEADS_RAS: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rasN) |-> $past(!casN && rasN)); // R6

  AST_RAS_TWO_CLOCKS: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rasN) |=> !rasN); // R6

  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rstN)
    cntWrEn |=> (cntValue == $past(cntWrData))); // R9

endmodule

bind refr_timer_top refr_checker #(.CNT_W(CNT_W), .SEL_W(SEL_W)) u_chk (
  .clk(clk), .rstN(rstN), .cntWrEn(cntWrEn), .cntWrData(cntWrData),
  .cntValue(cntValue), .selCode(selCode), .enFlag(enFlag),
  .busGrant(busGrant), .busReq(busReq), .rasN(rasN), .casN(casN)
);

// File: tb/test_refr_timer_top.sv
module test_refr_timer_top;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cntWrEn = 0, cmpWrEn = 0, selWrEn = 0, enWrEn = 0, enWrData = 0;
  logic [7:0] cntWrData = 0, cmpWrData = 0;
  logic [2:0] selWrData = 0;
  logic       busGrant = 0;
  logic       busReq, rasN, casN;
  logic [7:0] cntValue;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  refr_timer_top i_refr_timer_top (
    .clk(clk), .rstN(rstN),
    .cntWrEn(cntWrEn), .cntWrData(cntWrData),
    .cmpWrEn(cmpWrEn), .cmpWrData(cmpWrData),
    .selWrEn(selWrEn), .selWrData(selWrData),
    .enWrEn(enWrEn), .enWrData(enWrData),
    .busGrant(busGrant), .busReq(busReq), .rasN(rasN), .casN(casN),
    .cntValue(cntValue)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wrCnt(input logic [7:0] v);
    cntWrEn = 1; cntWrData = v; step(1); cntWrEn = 0;
  endtask
  task automatic wrCmp(input logic [7:0] v);
    cmpWrEn = 1; cmpWrData = v; step(1); cmpWrEn = 0;
  endtask
  task automatic wrSel(input logic [2:0] v);
    selWrEn = 1; selWrData = v; step(1); selWrEn = 0;
  endtask
  task automatic wrEn(input logic v);
    enWrEn = 1; enWrData = v; step(1); enWrEn = 0;
  endtask

  function automatic int ratio(input int code);
    case (code)
      1: return 2;    2: return 8;    3: return 32;  4: return 128;
      5: return 512;  6: return 2048; default: return 4096;
    endcase
  endfunction

  // called right after the edge where grant is first sampled high in the wait state
  task automatic checkSequence(input string tag);
    check(!casN && rasN, {tag, " R6 cas-only"}, {casN, rasN}, 2'b01);
    step(1);
    check(!casN && !rasN, {tag, " R6 ras1"}, {casN, rasN}, 2'b00);
    step(1);
    check(!casN && !rasN, {tag, " R6 ras2"}, {casN, rasN}, 2'b00);
    step(1);
    check(casN && rasN && busReq, {tag, " R6 precharge"}, {casN, rasN, busReq}, 3'b111);
    step(1);
    check(!busReq, {tag, " R6 release"}, busReq, 0);
  endtask

  task automatic tReset();
    check(cntValue == 0, "R10 counter", cntValue, 0);
    check(!busReq, "R10 request", busReq, 0);
    check(rasN && casN, "R10 strobes", {rasN, casN}, 2'b11);
  endtask

  task automatic tHold();
    wrCnt(8'd5);
    step(20);
    check(cntValue == 5, "R2 held at select 0", cntValue, 5);
  endtask

  task automatic tRates();
    int codes[3] = '{1, 3, 7};
    wrCmp(8'd255);
    foreach (codes[i]) begin
      int a, reps;
      reps = (codes[i] == 7) ? 2 : 3;
      wrCnt(8'd0);
      wrSel(3'(codes[i]));
      a = cntValue;
      step(reps * ratio(codes[i]));
      check(int'(cntValue) - a == reps, $sformatf("R3 code %0d", codes[i]),
            int'(cntValue) - a, reps);
      wrSel(3'd0);
    end
  endtask

  task automatic tWrapNoEnable();
    int maxv = 0;
    bit sawTop = 0, sawWrap = 0, sawReq = 0;
    wrCmp(8'd3);
    wrCnt(8'd0);
    wrSel(3'd1);
    for (int i = 0; i < 40; i++) begin
      step(1);
      if (cntValue > maxv) maxv = cntValue;
      if (cntValue == 3) sawTop = 1;
      if (sawTop && cntValue == 0) sawWrap = 1;
      if (busReq) sawReq = 1;
    end
    check(maxv == 3, "R4 counter peak", maxv, 3);
    check(sawWrap, "R4 wrap to zero", sawWrap, 1);
    check(!sawReq, "R1 no request when disabled", sawReq, 0);
    wrSel(3'd0);
  endtask

  task automatic tPending();
    bit lateReq = 0;
    wrCnt(8'd0);
    wrCmp(8'd3);
    wrEn(1'b1);
    busGrant = 0;
    wrSel(3'd1);
    step(40);
    check(busReq, "R5 request pending", busReq, 1);
    check(rasN && casN, "R5 strobes idle without grant", {rasN, casN}, 2'b11);
    wrCmp(8'd200);
    busGrant = 1;
    step(1);
    checkSequence("pending");
    busGrant = 0;
    for (int i = 0; i < 30; i++) begin
      step(1);
      if (busReq) lateReq = 1;
    end
    check(!lateReq, "R7 earlier matches dropped", lateReq, 0);
    wrSel(3'd0);
  endtask

  task automatic tActiveDrop();
    int n = 0;
    bit lateReq = 0;
    wrCnt(8'd0);
    wrCmp(8'd20);
    busGrant = 1;
    wrSel(3'd1);
    while (!busReq && n < 200) begin step(1); n++; end
    check(busReq, "R5 request raised", busReq, 1);
    cntWrEn = 1; cntWrData = 8'd20;
    step(1);
    cntWrEn = 0;
    checkSequence("active");
    check(cntValue <= 4, "R8 counter reset by dropped match", cntValue, 0);
    for (int i = 0; i < 20; i++) begin
      step(1);
      if (busReq) lateReq = 1;
    end
    check(!lateReq, "R8 match during cycle dropped", lateReq, 0);
    busGrant = 0;
    wrSel(3'd0);
  endtask

  task automatic tPriority();
    bit sawReq = 0, kept = 1;
    wrCmp(8'd9);
    wrCnt(8'd0);
    wrSel(3'd1);
    cntWrEn = 1; cntWrData = 8'd9;
    for (int i = 0; i < 12; i++) begin
      step(1);
      if (cntValue != 9) kept = 0;
      if (busReq) sawReq = 1;
    end
    check(kept, "R9 write beats increment and reset", cntValue, 9);
    check(!sawReq, "R9 no match while writing", sawReq, 0);
    enWrEn = 1; enWrData = 0;
    step(1);
    cntWrEn = 0; enWrEn = 0;
    wrSel(3'd0);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    step(3);
    rstN = 1;
    step(1);
    tReset();
    tHold();
    tRates();
    tWrapNoEnable();
    tPending();
    tActiveDrop();
    tPriority();
    summary();
  end

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    summary();
  end

endmodule